// File: doc/BRIEF.md
# Key Matrix Scanner with Serial Image Readout

This block scans a key matrix of 12 source columns by 4 return rows. It drives one source column at a time and samples the four return lines at the end of each scan slot. The samples go into a shadow store. The display multiplexer supplies the timing: a strobe at the end of every scan slot and a strobe at the end of every display frame. One complete scan takes two frames. The first frame covers columns 1 to 6 and the second covers columns 7 to 12. The shadow is copied into the readable key image in one step, and only at the end of the second frame, which is the end of the display cycle.

The image holds six bytes. Each byte covers a pair of columns. Software reads the image one bit per shift strobe through the serial interface, least significant bit first. The read crosses from one byte into the next without a gap. Control inputs stop scanning when the display mode changes and start it again when a display-on command arrives.

Top module: `key_scanner`

## Requirements
- R1: After reset, scanning is stopped and no source column is driven, even when slot strobes arrive. The key image is all zeros, and the read pointer is at byte 0, bit 0.
- R2: When a display-on pulse arrives while scanning is stopped, scanning starts in the first frame half. From the next cycle on, column 1 (`src_drv[0]`) is driven.
- R3: At most one source column is driven at any time. Each slot strobe moves to the next column. In the first frame half the columns run 1 to 6, and in the second half they run 7 to 12. After the sixth slot of a half, nothing is driven until the frame strobe. The frame strobe switches to the other half and restarts at its first column.
- R4: The return inputs are sampled at each slot strobe into the shadow entry of the column currently driven. The readable image does not change during a scan cycle.
- R5: A frame strobe that ends the second frame half copies the whole shadow into the image in a single cycle.
- R6: Image byte n (n = 0 to 5) holds column 2n+1 in bits 0..3 and column 2n+2 in bits 4..7. Within each nibble, bit 0 is return row 1 and bit 3 is return row 4. A return input at 1 means the key is pressed.
- R7: `rd_bit` shows the image bit at the read pointer. Each `rd_shift` advances the pointer by one bit. After bit 7 of a byte, the pointer moves to bit 0 of the next byte. After byte 5, bit 7, it returns to byte 0, bit 0.
- R8: An `rd_start` pulse, which marks a newly accepted key-read command, puts the pointer at byte 0, bit 0. It takes priority over `rd_shift`.
- R9: A mode-change pulse stops scanning, and from the next cycle no column is driven. Slot and frame strobes have no effect while scanning is stopped, and the image stays unchanged. The next display-on pulse restarts the scan at column 1.
- R10: A display-on pulse that arrives while scanning is running changes nothing. The current column stays driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | Pulse at the end of a scan slot |
| frame_tick | input | 1 | Pulse at the end of a display frame |
| mode_chg | input | 1 | Pulse when the display mode changes; stops scanning |
| disp_on | input | 1 | Pulse for a display-on command; starts scanning |
| key_ret | input | NROW | Key return inputs, 1 = pressed |
| src_drv | output | NCOL | One-hot drive of the scan source columns |
| rd_start | input | 1 | Pulse when a key-read command is accepted |
| rd_shift | input | 1 | Pulse that advances the read pointer by one bit |
| rd_bit | output | 1 | Image bit at the read pointer |

## Verification
The bench models a key matrix in which each pressed key connects its column to its row. The return inputs therefore depend only on the column the design drives. First a single pressed key is walked across all 48 positions. Each result locates that key in exactly one byte, nibble and row bit, so any swap between nibbles or columns, or any bit-order error in the packing, shows up. Then dense and alternating patterns, including all keys pressed, show whether rows or columns leak into one another. In every scan cycle the bench reads the image just before the closing frame strobe, to confirm the commit is delayed to that strobe, and again after it. Separate sequences cover the read wrap from byte 5 back to byte 0, the pointer restart, a stop in mid-scan followed by idle strobes, and a redundant display-on pulse.

// File: rtl/key_scanner.sv
module key_scanner #(
  parameter int NCOL = 12,
  parameter int NROW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slot_tick,
  input  logic            frame_tick,
  input  logic            mode_chg,
  input  logic            disp_on,
  input  logic [NROW-1:0] key_ret,
  output logic [NCOL-1:0] src_drv,
  input  logic            rd_start,
  input  logic            rd_shift,
  output logic            rd_bit
);
  localparam int HALF  = NCOL / 2;
  localparam int SW    = $clog2(HALF + 1);
  localparam int CW    = $clog2(NCOL);
  localparam int IMG   = NCOL * NROW;
  localparam int IW    = $clog2(IMG);
  localparam int BW    = 2 * NROW;
  localparam int NBYTE = NCOL / 2;
  localparam int BYW   = $clog2(NBYTE);
  localparam int BIW   = $clog2(BW);

  logic           run, half;
  logic [SW-1:0]  slot;
  logic [IMG-1:0] shadow, image;
  logic [BYW-1:0] ptr_byte;
  logic [BIW-1:0] ptr_bit;

  logic [CW-1:0]  col;
  logic           active, commit;
  logic [IW-1:0]  sidx, ridx;

  assign col    = half ? CW'(HALF) + CW'(slot) : CW'(slot);
  assign active = run && (slot < SW'(HALF));
  assign commit = run && frame_tick && half;
  assign sidx   = IW'(col) * IW'(NROW);
  assign ridx   = IW'(ptr_byte) * IW'(BW) + IW'(ptr_bit);
  assign rd_bit = image[ridx];

  for (genvar i = 0; i < NCOL; i++) begin : g_src
    assign src_drv[i] = active && (col == CW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      half <= 1'b0;
      slot <= '0;
    end else if (mode_chg) begin
      run  <= 1'b0;
      half <= 1'b0;
      slot <= '0;
    end else if (!run) begin
      if (disp_on) begin
        run  <= 1'b1;
        half <= 1'b0;
        slot <= '0;
      end
    end else if (frame_tick) begin
      half <= ~half;
      slot <= '0;
    end else if (slot_tick && active) begin
      slot <= slot + SW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      image  <= '0;
    end else begin
      if (slot_tick && active && !mode_chg)
        shadow[sidx +: NROW] <= key_ret;
      if (commit && !mode_chg)
        image <= shadow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rd_start) begin
      ptr_byte <= '0;
      ptr_bit  <= '0;
    end else if (rd_shift) begin
      if (ptr_bit == BIW'(BW - 1)) begin
        ptr_bit  <= '0;
        ptr_byte <= (ptr_byte == BYW'(NBYTE - 1)) ? '0 : ptr_byte + BYW'(1);
      end else begin
        ptr_bit <= ptr_bit + BIW'(1);
      end
    end
  end

  // R3
  one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_drv));

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (src_drv == '0));

  // R4
  img_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_start && !rd_shift && !commit) |=> $stable(rd_bit));

  // R5
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !mode_chg) |=> (image == $past(shadow)));

  // R8
  rd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> (rd_bit == image[0]));

  // R7
  always_comb begin
    if (rst_n) ptr_range_chk: assert (ptr_byte < BYW'(NBYTE));
  end
endmodule

// File: tb/sim_key_scanner.sv
module sim_key_scanner;
  localparam int TCLK = 10;
  localparam int NCOL = 12;
  localparam int NROW = 4;
  localparam int HALF = NCOL / 2;
  localparam int IMG  = NCOL * NROW;

  logic clk = 0, rst_n = 0;
  logic slot_tick = 0, frame_tick = 0, mode_chg = 0, disp_on = 0;
  logic rd_start = 0, rd_shift = 0;
  logic [NROW-1:0] key_ret;
  logic [NCOL-1:0] src_drv;
  logic rd_bit;
  logic [IMG-1:0] press = '0;
  logic [IMG-1:0] prev_exp = '0;
  logic [IMG-1:0] got;
  int checks = 0, fails = 0;

  always #(TCLK/2) clk = ~clk;

  key_scanner #(.NCOL(NCOL), .NROW(NROW)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .frame_tick(frame_tick),
    .mode_chg(mode_chg), .disp_on(disp_on), .key_ret(key_ret),
    .src_drv(src_drv), .rd_start(rd_start), .rd_shift(rd_shift), .rd_bit(rd_bit));

  always_comb begin
    key_ret = '0;
    for (int c = 0; c < NCOL; c++)
      if (src_drv[c]) key_ret = key_ret | press[c*NROW +: NROW];
  end

  task automatic chk(input bit ok, input string req, input logic [IMG-1:0] act, input logic [IMG-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [IMG-1:0] pack(input logic [IMG-1:0] p);
    logic [IMG-1:0] r;
    for (int k = 0; k < IMG; k++) begin
      int byte_n = k / 8;
      int bit_n  = k % 8;
      int c      = 2 * byte_n + (bit_n >= 4 ? 1 : 0);
      r[k] = p[c*NROW + (bit_n % 4)];
    end
    return r;
  endfunction

  task automatic pulse_slot;  @(negedge clk) slot_tick = 1;  @(negedge clk) slot_tick = 0;  endtask
  task automatic pulse_frame; @(negedge clk) frame_tick = 1; @(negedge clk) frame_tick = 0; endtask
  task automatic pulse_on;    @(negedge clk) disp_on = 1;    @(negedge clk) disp_on = 0;    endtask
  task automatic pulse_mode;  @(negedge clk) mode_chg = 1;   @(negedge clk) mode_chg = 0;   endtask
  task automatic pulse_shift; @(negedge clk) rd_shift = 1;   @(negedge clk) rd_shift = 0;   endtask
  task automatic pulse_rdst;  @(negedge clk) rd_start = 1;   @(negedge clk) rd_start = 0;   endtask

  task automatic read_img(output logic [IMG-1:0] v);
    pulse_rdst();
    v[0] = rd_bit;
    for (int k = 1; k < IMG; k++) begin
      pulse_shift();
      v[k] = rd_bit;
    end
  endtask

  task automatic run_cycle(input logic [IMG-1:0] p);
    bit seq_ok = 1;
    logic [IMG-1:0] v;
    press = p;
    for (int f = 0; f < 2; f++) begin
      for (int s = 0; s < HALF; s++) begin
        if (src_drv != NCOL'(1) << (f*HALF + s)) seq_ok = 0;
        pulse_slot();
      end
      if (src_drv != '0) seq_ok = 0;
      if (f == 1) begin
        read_img(v);
        chk(v == prev_exp, "R4 image held until cycle end", v, prev_exp);
      end
      pulse_frame();
    end
    chk(seq_ok, "R3 column order", IMG'(src_drv), '0);
    read_img(v);
    chk(v == pack(p), "R5 R6 committed image", v, pack(p));
    prev_exp = pack(p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", '0, '1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [IMG-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(src_drv == '0, "R1 no drive after reset", IMG'(src_drv), '0);
    chk(rd_bit == 0, "R1 image bit zero", IMG'(rd_bit), '0);
    pulse_slot();
    chk(src_drv == '0, "R1 stopped ignores slot", IMG'(src_drv), '0);
    read_img(v);
    chk(v == '0, "R1 image zero", v, '0);

    pulse_on();
    chk(src_drv == NCOL'(1), "R2 starts at column 1", IMG'(src_drv), 1);

    for (int k = 0; k < IMG; k++) run_cycle(IMG'(1) << k);
    run_cycle({IMG{1'b1}});
    run_cycle({(IMG/2){2'b10}});
    run_cycle({(IMG/8){8'hF0}});
    run_cycle(48'h5A3C_96E1_0F7B);
    run_cycle('0);

    run_cycle(IMG'(1));
    pulse_rdst();
    for (int k = 0; k < IMG; k++) pulse_shift();
    chk(rd_bit == 1, "R7 wrap to byte 0 bit 0", IMG'(rd_bit), 1);
    pulse_shift();
    chk(rd_bit == 0, "R7 next bit after wrap", IMG'(rd_bit), 0);
    for (int k = 0; k < 5; k++) pulse_shift();
    pulse_rdst();
    chk(rd_bit == 1, "R8 pointer restart", IMG'(rd_bit), 1);
    @(negedge clk) rd_start = 1; rd_shift = 1;
    @(negedge clk) rd_start = 0; rd_shift = 0;
    chk(rd_bit == 1, "R8 start beats shift", IMG'(rd_bit), 1);

    press = {IMG{1'b1}};
    repeat (3) pulse_slot();
    pulse_mode();
    chk(src_drv == '0, "R9 stop on mode change", IMG'(src_drv), '0);
    pulse_slot(); pulse_frame(); pulse_slot(); pulse_frame(); pulse_frame();
    chk(src_drv == '0, "R9 stays stopped", IMG'(src_drv), '0);
    read_img(v);
    chk(v == prev_exp, "R9 image untouched while stopped", v, prev_exp);
    pulse_on();
    chk(src_drv == NCOL'(1), "R9 resume at column 1", IMG'(src_drv), 1);
    run_cycle({IMG{1'b1}});

    pulse_slot(); pulse_slot();
    chk(src_drv == NCOL'(4), "R10 mid-scan column 3", IMG'(src_drv), 4);
    pulse_on();
    chk(src_drv == NCOL'(4), "R10 redundant display-on", IMG'(src_drv), 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule